// File: doc/BRIEF.md
# Self-correcting synchronous modulus counter

This block is a synchronous counter whose cycle length is set by a parameter: a decade sequence (four state bits, values 0 to 9) or a three-step sequence (two state bits, values 0 to 2). Every state bit is held in a JK-style cell. Per-bit set and clear terms decide the next value. The decade set keeps J=K=1 on bit 0 and uses J1=Q0·~Q3, K1=Q0, J2=K2=Q0·Q1, J3=Q0·Q1·Q2 and K3=Q0. The three-step set drives each cell as a D stage, with next bit 1 = Q0 and next bit 0 = ~Q1·~Q0.

The codes the sequence never visits are not left to chance. Each one has a defined successor, so a counter that starts in an unused code, or is forced into one, returns to the sequence within a small fixed number of clocks. It never locks up. A test load port can force any code, including unused ones, so that this recovery can be exercised. The outputs are the count, a flag on the last value of the sequence, and a flag that is high whenever the held code is unused.

Top module: `modcnt_selfheal`

## Requirements
- R1: A high `rst` at a rising clock edge makes `count` zero after that edge. `rst` takes precedence over `load` and `en`.
- R2: With MODULUS=10, each rising edge with `en` high and `load` and `rst` low steps `count` from n to n+1 for n below 9, and from 9 to 0.
- R3: With `en`, `load` and `rst` all low, `count` keeps its value across the edge. This holds for unused codes as well, so no recovery step takes place.
- R4: A high `load` with `rst` low makes `count` equal `load_val` after the edge, whatever the level of `en`. Any code may be loaded.
- R5: With MODULUS=10, an enabled step from an unused code gives these successors: 1010 to 1011, 1011 to 0100, 1100 to 1101, 1101 to 0100, 1110 to 1111, and 1111 to 0000.
- R6: Once `count` holds an unused code, at most two enabled steps are taken from unused codes before `count` holds a value of the sequence again.
- R7: With MODULUS=3, enabled steps follow 00, 01, 10, 00, and the unused code 11 steps to 10.
- R8: `term` is high exactly when `count` equals MODULUS-1: 9 for the decade counter and 2 for the three-step counter.
- R9: `invalid` is high exactly when `count` is at least MODULUS, which is an unused code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| load | input | 1 | Test load strobe |
| load_val | input | W (4 for MODULUS=10, 2 for MODULUS=3) | Code written by `load` |
| count | output | W | Current state |
| term | output | 1 | Last value of the sequence |
| invalid | output | 1 | Held code is unused |

## Verification
Three controls can meet on the same edge: a load can fall on a cycle that would otherwise step the counter, and a reset can fall on a cycle that carries a load. The bench drives these collisions directly, including a load of an unused code together with an enabled step and a reset together with a load of a legal code. It also produces them at random. A reference model written from the priority order rst, then load, then en judges each case by the count, `term` and `invalid` seen in the next cycle. Recovery is exercised by loading each unused code and stepping it, both with the enable held low (the code must stay) and with the enable high (the listed successor must appear).

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

    // Set/clear pair applied to one JK-style state cell
    typedef struct packed {
        logic j;
        logic k;
    } jk_pair_t;

    // Output flags decoded from the held state
    typedef struct packed {
        logic term;
        logic invalid;
    } cnt_flags_t;

    // Number of state bits for a supported modulus
    function automatic int cnt_width(input int modulus);
        return (modulus > 4) ? 4 : 2;
    endfunction

    // JK characteristic: a set bit obeys k, a clear bit obeys j
    function automatic logic jk_next(input logic q, input jk_pair_t p);
        return q ? ~p.k : p.j;
    endfunction

    // Express a D-style next value as a set/clear pair
    function automatic jk_pair_t d_as_jk(input logic d);
        jk_pair_t p;
        p.j = d;
        p.k = ~d;
        return p;
    endfunction

endpackage

// File: rtl/modcnt_jk_cell.sv
module modcnt_jk_cell
    import modcnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     load,
    input  logic     load_bit,
    input  jk_pair_t jk,
    output logic     q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (load) begin
            q <= load_bit;
        end else if (en) begin
            q <= jk_next(q, jk);
        end
    end

endmodule

// File: rtl/modcnt_excite.sv
module modcnt_excite
    import modcnt_pkg::*;
#(
    parameter int MODULUS = 10,
    localparam int W = cnt_width(MODULUS)
) (
    input  logic     [W-1:0] q,
    output jk_pair_t [W-1:0] jk
);

    generate
        if (MODULUS == 10) begin : g_decade
            // Groupings chosen so every unused code reaches the sequence
            always_comb begin
                jk[0].j = 1'b1;
                jk[0].k = 1'b1;
                jk[1].j = q[0] & ~q[3];
                jk[1].k = q[0];
                jk[2].j = q[0] & q[1];
                jk[2].k = q[0] & q[1];
                jk[3].j = q[0] & q[1] & q[2];
                jk[3].k = q[0];
            end
        end else begin : g_ternary
            // D-style stages: unused 11 steps to 10
            always_comb begin
                jk[1] = d_as_jk(q[0]);
                jk[0] = d_as_jk(~q[1] & ~q[0]);
            end
        end
    endgenerate

endmodule

// File: rtl/modcnt_decode.sv
module modcnt_decode
    import modcnt_pkg::*;
#(
    parameter int MODULUS = 10,
    localparam int W = cnt_width(MODULUS)
) (
    input  logic [W-1:0] q,
    output cnt_flags_t   flags
);

    localparam logic [W-1:0] LAST_CODE  = W'(MODULUS - 1);
    localparam logic [W-1:0] FIRST_UNUSED = W'(MODULUS);

    always_comb begin
        flags.term    = (q == LAST_CODE);
        flags.invalid = (q >= FIRST_UNUSED);
    end

endmodule

// File: rtl/modcnt_selfheal.sv
module modcnt_selfheal
    import modcnt_pkg::*;
#(
    parameter int MODULUS = 10,
    localparam int W = cnt_width(MODULUS)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         term,
    output logic         invalid
);

    logic     [W-1:0] state_q;
    jk_pair_t [W-1:0] jk_bank;
    cnt_flags_t       flags;

    modcnt_excite #(.MODULUS(MODULUS)) u_excite (
        .q  (state_q),
        .jk (jk_bank)
    );

    generate
        for (genvar b = 0; b < W; b++) begin : g_cell
            modcnt_jk_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .en       (en),
                .load     (load),
                .load_bit (load_val[b]),
                .jk       (jk_bank[b]),
                .q        (state_q[b])
            );
        end
    endgenerate

    modcnt_decode #(.MODULUS(MODULUS)) u_decode (
        .q     (state_q),
        .flags (flags)
    );

    assign count   = state_q;
    assign term    = flags.term;
    assign invalid = flags.invalid;

endmodule

// File: rtl/modcnt_checker.sv
module modcnt_checker #(
    parameter int MODULUS = 10,
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         load,
    input logic [W-1:0] load_val,
    input logic [W-1:0] count,
    input logic         term,
    input logic         invalid
);

    localparam logic [W-1:0] LAST_CODE = W'(MODULUS - 1);
    localparam logic [W-1:0] FIRST_UNUSED = W'(MODULUS);
    localparam logic [W-1:0] ONE = W'(1);

    // Enabled steps already taken from unused codes in the current stretch
    logic [1:0] bad_steps;
    always_ff @(posedge clk) begin
        if (rst || load || (count < FIRST_UNUSED)) begin
            bad_steps <= 2'd0;
        end else if (en && bad_steps != 2'd3) begin
            bad_steps <= bad_steps + 2'd1;
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> count == '0);

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && en && count < LAST_CODE) |=> count == $past(count) + ONE);

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && en && count == LAST_CODE) |=> count == '0);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(count));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));

    assert_recover_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !load && count >= FIRST_UNUSED) |-> bad_steps <= 2'd1);

    assert_term_R8: assert property (@(posedge clk) disable iff (rst)
        term == (count == LAST_CODE));

    assert_invalid_R9: assert property (@(posedge clk) disable iff (rst)
        invalid == (count >= FIRST_UNUSED));

    generate
        if (MODULUS == 10) begin : g_dec_chk
            assert_exit_1010_R5: assert property (@(posedge clk) disable iff (rst)
                (!load && en && count == W'(10)) |=> count == W'(11));
            assert_exit_1111_R5: assert property (@(posedge clk) disable iff (rst)
                (!load && en && count == W'(15)) |=> count == '0);
        end else begin : g_ter_chk
            assert_exit_11_R7: assert property (@(posedge clk) disable iff (rst)
                (!load && en && count == W'(3)) |=> count == W'(2));
        end
    endgenerate

endmodule

bind modcnt_selfheal modcnt_checker #(.MODULUS(MODULUS), .W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .load_val (load_val),
    .count    (count),
    .term     (term),
    .invalid  (invalid)
);

// File: tb/sim_modcnt_selfheal.sv
`timescale 1ns/1ps
module sim_modcnt_selfheal;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, en = 1'b0, load = 1'b0;
    logic [3:0] lv10 = '0;
    logic [1:0] lv3 = '0;
    logic [3:0] c10;
    logic [1:0] c3;
    logic t10, i10, t3, i3;

    int total = 0;
    int bad = 0;
    int run10 = 0;
    logic [3:0] m10 = '0;
    logic [1:0] m3 = '0;

    modcnt_selfheal #(.MODULUS(10)) u0 (
        .clk(clk), .rst(rst), .en(en), .load(load), .load_val(lv10),
        .count(c10), .term(t10), .invalid(i10));

    modcnt_selfheal #(.MODULUS(3)) u1 (
        .clk(clk), .rst(rst), .en(en), .load(load), .load_val(lv3),
        .count(c3), .term(t3), .invalid(i3));

    // Successor tables written from R2, R5 and R7
    function automatic logic [3:0] succ10(input logic [3:0] q);
        case (q)
            4'd9:  return 4'd0;
            4'd10: return 4'd11;
            4'd11: return 4'd4;
            4'd12: return 4'd13;
            4'd13: return 4'd4;
            4'd14: return 4'd15;
            4'd15: return 4'd0;
            default: return q + 4'd1;
        endcase
    endfunction

    function automatic logic [1:0] succ3(input logic [1:0] q);
        case (q)
            2'd0: return 2'd1;
            2'd1: return 2'd2;
            2'd2: return 2'd0;
            default: return 2'd2;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle, update the model at the edge, compare at the next falling edge
    task automatic cyc(input logic r, input logic e, input logic l,
                       input logic [3:0] v10, input logic [1:0] v3, input string tag);
        rst = r; en = e; load = l; lv10 = v10; lv3 = v3;
        @(posedge clk);
        if (r) begin m10 = '0; m3 = '0; run10 = 0; end
        else if (l) begin m10 = v10; m3 = v3; run10 = (v10 >= 4'd10) ? 1 : 0; end
        else if (e) begin
            m10 = succ10(m10); m3 = succ3(m3);
            run10 = (m10 >= 4'd10) ? run10 + 1 : 0;
        end
        @(negedge clk);
        chk({tag, " count10"}, int'(c10), int'(m10));
        chk({tag, " count3"}, int'(c3), int'(m3));
        chk("R8 term10", int'(t10), int'(m10 == 4'd9));
        chk("R8 term3", int'(t3), int'(m3 == 2'd2));
        chk("R9 invalid10", int'(i10), int'(m10 >= 4'd10));
        chk("R9 invalid3", int'(i3), int'(m3 == 2'd3));
        chk("R6 unused run", int'(run10 <= 2), 1);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        cyc(1, 0, 0, 0, 0, "R1 reset");
        for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 0, "R2 R7 sequence");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, "R3 hold");
        for (int u = 10; u < 16; u++) begin
            cyc(0, 0, 1, 4'(u), 2'd3, "R4 load unused");
            cyc(0, 0, 0, 0, 0, "R3 unused held");
            cyc(0, 1, 0, 0, 0, "R5 R7 first step");
            cyc(0, 1, 0, 0, 0, "R5 R6 second step");
        end
        cyc(0, 1, 1, 4'd12, 2'd3, "R4 load beats enable");
        cyc(1, 1, 1, 4'd7, 2'd1, "R1 reset beats load");
        cyc(0, 1, 1, 4'd9, 2'd2, "R4 load last");
        cyc(0, 1, 0, 0, 0, "R2 R7 wrap");
        for (int i = 0; i < 4000; i++) begin
            logic r, e, l;
            r = ($urandom % 64) == 0;
            l = ($urandom % 8) == 0;
            e = ($urandom % 4) != 0;
            cyc(r, e, l, 4'($urandom), 2'($urandom), "R2 R3 R4 R5 R7 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule